// File: doc/BRIEF.md
# I2C Register Access Transaction Controller

This block runs whole register-level transactions on an I2C bus: probe, write and read. It sits above a bit-level sequencer that produces the bus conditions and the bit timing. The controller turns one request into the right series of sequencer commands: START, byte writes, byte reads, and STOP. It checks the acknowledge returned for each byte written and reports a status code with a one-cycle done strobe.

A request carries a 7-bit chip address, an internal address of 0 to `ADDR_BYTES` bytes, a byte count and an operation. The internal address is sent most significant byte first. On a read with a non-zero address length, the controller first writes the internal address. It then closes that phase with a full STOP and opens the read with a fresh START.

Write data is pulled from a valid/ready byte stream, one byte for each data slot. Each received byte is pushed out with a one-cycle valid pulse. When address folding is enabled, the internal-address bits that lie above the used address bytes are masked and ORed into the chip address. This serves memories that keep extra address bits in the chip address field.

Top module: `i2cRegTxn`

## Requirements
- R1: A probe (reqOp=0) issues START, a write of {chip,0}, then STOP. Its status is 1 if that byte was NACKed and 0 otherwise.
- R2: On a write, or on a read with non-zero address length, a NACK of the first {chip,0} byte is followed by STOP and ends the transaction with status 1. No address or data bytes are sent.
- R3: Internal address bytes are written most significant byte first. A NACK on any of them ends the transaction at once with status 1, with no STOP and no further command.
- R4: A read (reqOp=2) with non-zero address length sends START, {chip,0} and the address bytes, then STOP, then START, then {chip,1}, then the read bytes.
- R5: A read with address length 0 skips the address phase. It begins with START followed directly by {chip,1}.
- R6: Every read byte except the last is requested with seqAckOut=0 (ACK); the last one with seqAckOut=1 (NACK), followed by STOP. Each received byte appears on rdData with a one-cycle rdValid pulse, in bus order. A read returns status 0.
- R7: With ovfEn=1, the chip address used is reqChip OR ((reqAddr >> 8*reqAlen) AND ovfMask). With ovfEn=0 it is reqChip unchanged.
- R8: On a write (reqOp=1), a NACK on a data byte does not stop the transfer. Status after the final STOP equals the number of NACKed data bytes.
- R9: A write of length 0 sends START, the chip byte and the address bytes, then STOP, and returns status 0 when all were ACKed.
- R10: done is a one-cycle pulse with status valid in the same cycle. A request is accepted only while reqReady is high. reqReady is high in the cycle done is high, so a held request starts right away.
- R11: Write data is taken with wrReady only between commands, one byte per data slot. Bytes are sent in stream order, and no byte is pulled beyond reqLen.
- R12: Sequencer command codes on seqCmd are 0 START, 1 STOP, 2 WRITE seqTxByte, 3 READ. A command is held with seqCmdValid until a one-cycle seqDone. seqNack is sampled with seqDone for writes, and seqRxByte with seqDone for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request taken |
| reqOp | input | 2 | 0 probe, 1 write, 2 read |
| reqChip | input | 7 | Chip address |
| reqAddr | input | 8*ADDR_BYTES | Internal address |
| reqAlen | input | clog2(ADDR_BYTES+1) | Internal address length in bytes |
| reqLen | input | LEN_W | Data byte count |
| ovfEn | input | 1 | Enable folding of high address bits into chip address |
| ovfMask | input | 7 | Mask of chip bits that may be folded |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte taken |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte pulse |
| rdData | output | 8 | Read byte |
| seqCmdValid | output | 1 | Command to sequencer held |
| seqCmd | output | 2 | Command code |
| seqTxByte | output | 8 | Byte for WRITE |
| seqAckOut | output | 1 | Level driven in acknowledge slot of READ (1 = NACK) |
| seqDone | input | 1 | Command completed |
| seqNack | input | 1 | Acknowledge slot was high on a WRITE |
| seqRxByte | input | 8 | Byte received by READ |
| done | output | 1 | Transaction finished pulse |
| status | output | LEN_W | Result code |

## Verification
Two events can meet in one cycle: the completion of a transaction, shown by done and its status, and the acceptance of the next request. The bench provokes this by holding reqValid high through a whole probe and changing the request fields in the cycle done appears. It then checks three things. The first status still reads the first result. reqReady is high in that same cycle. The command trace shows two complete, intact probe sequences, one after the other, with the second carrying the new chip address and its own status.

// File: rtl/i2cTxnPkg.sv
package i2cTxnPkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } seqCmd_t;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } txnOp_t;

  typedef enum logic [1:0] {
    TX_CHIP = 2'd0,
    TX_ADDR = 2'd1,
    TX_DATA = 2'd2
  } txSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadReq;
    logic   decAlen;
    logic   loadData;
    logic   decLen;
    logic   incFail;
    logic   markErr;
    logic   pushRd;
    logic   finish;
    txSel_t txSel;
    logic   rwBit;
  } dpStrobe_t;

endpackage

// File: rtl/i2cTxnDatapath.sv
module i2cTxnDatapath
  import i2cTxnPkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [6:0]        reqChip,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ALEN_W-1:0] reqAlen,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              ovfEn,
  input  logic [6:0]        ovfMask,
  input  logic [7:0]        wrData,
  input  logic [7:0]        seqRxByte,
  output logic [7:0]        txByte,
  output logic              alenZero,
  output logic              alenLast,
  output logic              lenZero,
  output logic              lenLast,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              done,
  output logic [LEN_W-1:0]  status
);

  logic [6:0]        chipReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ALEN_W-1:0] alenCnt;
  logic [LEN_W-1:0]  lenCnt;
  logic [LEN_W-1:0]  failCnt;
  logic [7:0]        dataReg;
  logic              errFlag;

  logic [6:0]        foldHi;
  logic [6:0]        chipEff;
  logic [ALEN_W-1:0] byteIdx;
  logic [7:0]        addrByte;

  // high address bits above the used bytes, folded into the chip field
  assign foldHi  = 7'(reqAddr >> {reqAlen, 3'b000});
  assign chipEff = ovfEn ? (reqChip | (foldHi & ovfMask)) : reqChip;

  // most significant remaining address byte
  assign byteIdx  = alenCnt - ALEN_W'(1);
  assign addrByte = 8'(addrReg >> {byteIdx, 3'b000});

  always_comb begin
    case (st.txSel)
      TX_ADDR: txByte = addrByte;
      TX_DATA: txByte = dataReg;
      default: txByte = {chipReg, st.rwBit};
    endcase
  end

  assign alenZero = (alenCnt == '0);
  assign alenLast = (alenCnt == ALEN_W'(1));
  assign lenZero  = (lenCnt == '0);
  assign lenLast  = (lenCnt == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipReg <= '0;
      addrReg <= '0;
      alenCnt <= '0;
      lenCnt  <= '0;
      failCnt <= '0;
      dataReg <= '0;
      errFlag <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
      done    <= 1'b0;
      status  <= '0;
    end else begin
      rdValid <= st.pushRd;
      done    <= st.finish;
      if (st.loadReq) begin
        chipReg <= chipEff;
        addrReg <= reqAddr;
        alenCnt <= reqAlen;
        lenCnt  <= reqLen;
        failCnt <= '0;
        errFlag <= 1'b0;
      end
      if (st.decAlen)  alenCnt <= alenCnt - ALEN_W'(1);
      if (st.decLen)   lenCnt  <= lenCnt - LEN_W'(1);
      if (st.loadData) dataReg <= wrData;
      if (st.incFail)  failCnt <= failCnt + LEN_W'(1);
      if (st.markErr)  errFlag <= 1'b1;
      if (st.pushRd)   rdData  <= seqRxByte;
      if (st.finish)   status  <= (errFlag || st.markErr) ? LEN_W'(1) : failCnt;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
  AST_FAIL_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN) st.incFail |-> (failCnt != '1)); // R8
  AST_ALEN_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) st.decAlen |-> !alenZero); // R3

endmodule

// File: rtl/i2cTxnCtrl.sv
module i2cTxnCtrl
  import i2cTxnPkg::*;
#(
  parameter int ADDR_BYTES = 4,
  localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ALEN_W-1:0] reqAlen,
  output logic              reqReady,
  input  logic              alenZero,
  input  logic              alenLast,
  input  logic              lenZero,
  input  logic              lenLast,
  input  logic              wrValid,
  output logic              wrReady,
  output logic              seqCmdValid,
  output seqCmd_t           seqCmd,
  output logic              seqAckOut,
  input  logic              seqDone,
  input  logic              seqNack,
  output dpStrobe_t         st
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_CHIP, S_ADDR, S_WPULL, S_WDATA, S_RDATA, S_STOP
  } state_t;

  state_t state, nextState;
  txnOp_t opReg, opIn;
  logic   rdPhase;
  logic   restartPend;

  always_comb begin
    case (reqOp)
      2'd1:    opIn = OP_WRITE;
      2'd2:    opIn = OP_READ;
      default: opIn = OP_PROBE;
    endcase
  end

  always_comb begin
    nextState   = state;
    st          = '0;
    reqReady    = 1'b0;
    wrReady     = 1'b0;
    seqCmdValid = 1'b0;
    seqCmd      = CMD_START;
    seqAckOut   = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.loadReq = 1'b1;
          nextState  = S_START;
        end
      end
      S_START: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_START;
        if (seqDone) nextState = S_CHIP;
      end
      S_CHIP: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_WRITE;
        st.txSel    = TX_CHIP;
        st.rwBit    = rdPhase;
        if (seqDone) begin
          if (opReg == OP_PROBE) begin
            st.markErr = seqNack;
            nextState  = S_STOP;
          end else if (rdPhase) begin
            nextState = lenZero ? S_STOP : S_RDATA;
          end else if (seqNack) begin
            st.markErr = 1'b1;
            nextState  = S_STOP;
          end else if (!alenZero) begin
            nextState = S_ADDR;
          end else begin
            nextState = lenZero ? S_STOP : S_WPULL;
          end
        end
      end
      S_ADDR: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_WRITE;
        st.txSel    = TX_ADDR;
        if (seqDone) begin
          st.decAlen = 1'b1;
          if (seqNack) begin
            st.markErr = 1'b1;
            st.finish  = 1'b1;
            nextState  = S_IDLE;
          end else if (alenLast) begin
            if (opReg == OP_READ) nextState = S_STOP;
            else                  nextState = lenZero ? S_STOP : S_WPULL;
          end
        end
      end
      S_WPULL: begin
        wrReady = 1'b1;
        if (wrValid) begin
          st.loadData = 1'b1;
          nextState   = S_WDATA;
        end
      end
      S_WDATA: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_WRITE;
        st.txSel    = TX_DATA;
        if (seqDone) begin
          st.decLen  = 1'b1;
          st.incFail = seqNack;
          nextState  = lenLast ? S_STOP : S_WPULL;
        end
      end
      S_RDATA: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_READ;
        seqAckOut   = lenLast;
        if (seqDone) begin
          st.pushRd = 1'b1;
          st.decLen = 1'b1;
          nextState = lenLast ? S_STOP : S_RDATA;
        end
      end
      S_STOP: begin
        seqCmdValid = 1'b1;
        seqCmd      = CMD_STOP;
        if (seqDone) begin
          if (restartPend) begin
            nextState = S_START;
          end else begin
            st.finish = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      opReg       <= OP_PROBE;
      rdPhase     <= 1'b0;
      restartPend <= 1'b0;
    end else begin
      state <= nextState;
      if (st.loadReq) begin
        opReg       <= opIn;
        rdPhase     <= (opIn == OP_READ) && (reqAlen == '0);
        restartPend <= 1'b0;
      end
      if (state == S_ADDR && seqDone && !seqNack && alenLast && opReg == OP_READ)
        restartPend <= 1'b1;
      if (state == S_STOP && seqDone && restartPend) begin
        restartPend <= 1'b0;
        rdPhase     <= 1'b1;
      end
    end
  end

  AST_WRREADY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN) wrReady |-> !seqCmdValid); // R11
  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN) st.finish |=> reqReady); // R10
  AST_ADDR_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN) (state == S_ADDR) |-> !alenZero); // R3

endmodule

// File: rtl/i2cRegTxn.sv
module i2cRegTxn
  import i2cTxnPkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [6:0]        reqChip,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ALEN_W-1:0] reqAlen,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              ovfEn,
  input  logic [6:0]        ovfMask,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [7:0]        wrData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              seqCmdValid,
  output logic [1:0]        seqCmd,
  output logic [7:0]        seqTxByte,
  output logic              seqAckOut,
  input  logic              seqDone,
  input  logic              seqNack,
  input  logic [7:0]        seqRxByte,
  output logic              done,
  output logic [LEN_W-1:0]  status
);

  dpStrobe_t st;
  seqCmd_t   cmdE;
  logic      alenZero, alenLast, lenZero, lenLast;

  i2cTxnCtrl #(.ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAlen(reqAlen), .reqReady(reqReady),
    .alenZero(alenZero), .alenLast(alenLast), .lenZero(lenZero), .lenLast(lenLast),
    .wrValid(wrValid), .wrReady(wrReady),
    .seqCmdValid(seqCmdValid), .seqCmd(cmdE), .seqAckOut(seqAckOut),
    .seqDone(seqDone), .seqNack(seqNack), .st(st)
  );

  i2cTxnDatapath #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .reqChip(reqChip), .reqAddr(reqAddr), .reqAlen(reqAlen), .reqLen(reqLen),
    .ovfEn(ovfEn), .ovfMask(ovfMask), .wrData(wrData), .seqRxByte(seqRxByte),
    .txByte(seqTxByte), .alenZero(alenZero), .alenLast(alenLast),
    .lenZero(lenZero), .lenLast(lenLast),
    .rdValid(rdValid), .rdData(rdData), .done(done), .status(status)
  );

  assign seqCmd = cmdE;

  AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(seqDone && seqCmdValid && (seqCmd == 2'd3))); // R6
  AST_NO_CMD_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !seqCmdValid); // R12

endmodule

// File: tb/tb_i2cRegTxn.sv
`timescale 1ns/1ps
module tb_i2cRegTxn;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [6:0]  reqChip = '0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqAlen = '0;
  logic [7:0]  reqLen = '0;
  logic        ovfEn = 1'b0;
  logic [6:0]  ovfMask = '0;
  logic        wrValid;
  logic        wrReady;
  logic [7:0]  wrData;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        seqCmdValid;
  logic [1:0]  seqCmd;
  logic [7:0]  seqTxByte;
  logic        seqAckOut;
  logic        seqDone = 1'b0;
  logic        seqNack = 1'b0;
  logic [7:0]  seqRxByte = '0;
  logic        done;
  logic [7:0]  status;

  always #2 clk = ~clk;

  i2cRegTxn dut (.*);

  int nChk = 0;
  int nBad = 0;

  // bench plans and sequencer/slave model state
  logic [63:0] nackPlan = '0;
  logic [7:0]  rxPlan [0:15];
  logic [7:0]  wrBuf  [0:15];
  int          wrCnt = 0;
  logic        clrReq = 1'b0;
  int          wrIdx, trN, wrCmdIdx, rxIdx, rdN, dly;
  logic        pend;
  logic [1:0]  trCmd  [0:63];
  logic [7:0]  trByte [0:63];
  logic        trAck  [0:63];
  logic [7:0]  rdGot  [0:15];

  logic [1:0]  exCmd  [0:63];
  logic [7:0]  exByte [0:63];
  logic        exAck  [0:63];
  int          exN;
  logic [7:0]  gotStatus;

  assign wrValid = (wrIdx < wrCnt);
  assign wrData  = wrBuf[wrIdx[3:0]];

  always @(posedge clk) begin
    seqDone <= 1'b0;
    if (!rstN || clrReq) begin
      pend <= 1'b0; dly <= 0; trN <= 0; wrCmdIdx <= 0; rxIdx <= 0; rdN <= 0; wrIdx <= 0;
    end else begin
      if (rdValid) begin rdGot[rdN[3:0]] <= rdData; rdN <= rdN + 1; end
      if (wrValid && wrReady) wrIdx <= wrIdx + 1;
      if (pend) begin
        if (dly == 0) begin seqDone <= 1'b1; pend <= 1'b0; end
        else dly <= dly - 1;
      end else if (seqCmdValid && !seqDone) begin
        pend <= 1'b1; dly <= 2;
        if (trN < 64) begin
          trCmd[trN] <= seqCmd; trByte[trN] <= seqTxByte; trAck[trN] <= seqAckOut;
          trN <= trN + 1;
        end
        seqNack <= 1'b0;
        if (seqCmd == 2'd2) begin seqNack <= nackPlan[wrCmdIdx[5:0]]; wrCmdIdx <= wrCmdIdx + 1; end
        if (seqCmd == 2'd3) begin seqRxByte <= rxPlan[rxIdx[3:0]]; rxIdx <= rxIdx + 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expClear(); exN = 0; endtask
  task automatic expPush(input logic [1:0] c, input logic [7:0] b, input logic a);
    exCmd[exN] = c; exByte[exN] = b; exAck[exN] = a; exN++;
  endtask

  task automatic cmpTrace(input string req);
    bit ok = (trN == exN);
    int firstBad = -1;
    chk(ok, req, "trace length", trN, exN);
    if (ok) begin
      for (int i = 0; i < exN; i++) begin
        if (firstBad < 0 && (trCmd[i] != exCmd[i] ||
            (exCmd[i] == 2'd2 && trByte[i] != exByte[i]) ||
            (exCmd[i] == 2'd3 && trAck[i] != exAck[i]))) firstBad = i;
      end
      if (firstBad >= 0)
        chk(1'b0, req, $sformatf("trace entry %0d cmd/byte/ack", firstBad),
            {trCmd[firstBad], trByte[firstBad], 7'd0, trAck[firstBad]},
            {exCmd[firstBad], exByte[firstBad], 7'd0, exAck[firstBad]});
      else chk(1'b1, req, "trace entries", 0, 0);
    end
  endtask

  task automatic clearModel();
    @(negedge clk) clrReq = 1'b1;
    @(negedge clk) clrReq = 1'b0;
  endtask

  task automatic runTxn(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] addr,
                        input int alen, input int len, input logic ovf, input logic [6:0] mask);
    clearModel();
    reqOp = op; reqChip = chip; reqAddr = addr; reqAlen = alen[2:0]; reqLen = len[7:0];
    ovfEn = ovf; ovfMask = mask; reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    while (!done) @(negedge clk);
    gotStatus = status;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R10", "reqReady after reset", reqReady, 1);
    chk(done == 1'b0, "R10", "done after reset", done, 0);
    chk(seqCmdValid == 1'b0, "R12", "seqCmdValid after reset", seqCmdValid, 0);
    chk(wrReady == 1'b0, "R11", "wrReady after reset", wrReady, 0);
    chk(rdValid == 1'b0, "R6", "rdValid after reset", rdValid, 0);
  endtask

  task automatic testProbe(input logic nack);
    nackPlan = {63'd0, nack}; wrCnt = 0;
    runTxn(2'd0, 7'h48, 32'h0, 0, 0, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'h90, 0); expPush(1, 0, 0);
    cmpTrace("R1");
    chk(gotStatus == {7'd0, nack}, "R1", "probe status", gotStatus, nack);
  endtask

  task automatic testWriteFails();
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33; wrCnt = 3;
    nackPlan = 64'b110000;
    runTxn(2'd1, 7'h50, 32'h1234, 2, 3, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'hA0, 0); expPush(2, 8'h12, 0); expPush(2, 8'h34, 0);
    expPush(2, 8'h11, 0); expPush(2, 8'h22, 0); expPush(2, 8'h33, 0); expPush(1, 0, 0);
    cmpTrace("R8 R11");
    chk(gotStatus == 8'd2, "R8", "write failure count", gotStatus, 2);
    chk(wrIdx == 3, "R11", "bytes pulled", wrIdx, 3);
  endtask

  task automatic testChipNack();
    wrBuf[0] = 8'h55; wrBuf[1] = 8'h66; wrCnt = 2;
    nackPlan = 64'b1;
    runTxn(2'd1, 7'h11, 32'h77, 1, 2, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'h22, 0); expPush(1, 0, 0);
    cmpTrace("R2");
    chk(gotStatus == 8'd1, "R2", "chip nack status", gotStatus, 1);
    chk(wrIdx == 0, "R2", "no data pulled after chip nack", wrIdx, 0);
  endtask

  task automatic testAddrNack();
    wrCnt = 0;
    nackPlan = 64'b100;
    runTxn(2'd1, 7'h3C, 32'h00ABCDEF, 3, 1, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'h78, 0); expPush(2, 8'hAB, 0); expPush(2, 8'hCD, 0);
    cmpTrace("R3");
    chk(gotStatus == 8'd1, "R3", "address nack status", gotStatus, 1);
  endtask

  task automatic testReadAddr();
    rxPlan[0] = 8'hA1; rxPlan[1] = 8'hB2; rxPlan[2] = 8'hC3; wrCnt = 0; nackPlan = '0;
    runTxn(2'd2, 7'h50, 32'h0010, 2, 3, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'hA0, 0); expPush(2, 8'h00, 0); expPush(2, 8'h10, 0);
    expPush(1, 0, 0); expPush(0, 0, 0); expPush(2, 8'hA1, 0);
    expPush(3, 0, 0); expPush(3, 0, 0); expPush(3, 0, 1); expPush(1, 0, 0);
    cmpTrace("R4 R6");
    chk(rdN == 3, "R6", "read pulses", rdN, 3);
    for (int i = 0; i < 3; i++)
      chk(rdGot[i] == rxPlan[i], "R6", $sformatf("read byte %0d", i), rdGot[i], rxPlan[i]);
    chk(gotStatus == 8'd0, "R6", "read status", gotStatus, 0);
  endtask

  task automatic testReadNoAddr();
    rxPlan[0] = 8'h5A; nackPlan = '0;
    runTxn(2'd2, 7'h68, 32'hFFFF, 0, 1, 1'b0, 7'h0);
    expClear(); expPush(0, 0, 0); expPush(2, 8'hD1, 0); expPush(3, 0, 1); expPush(1, 0, 0);
    cmpTrace("R5");
    chk(rdN == 1 && rdGot[0] == 8'h5A, "R5", "single read byte", rdGot[0], 8'h5A);
  endtask

  task automatic testFold();
    rxPlan[0] = 8'h3E; nackPlan = '0;
    runTxn(2'd2, 7'h50, 32'h2A5, 1, 1, 1'b1, 7'h07);
    expClear(); expPush(0, 0, 0); expPush(2, 8'hA4, 0); expPush(2, 8'hA5, 0); expPush(1, 0, 0);
    expPush(0, 0, 0); expPush(2, 8'hA5, 0); expPush(3, 0, 1); expPush(1, 0, 0);
    cmpTrace("R7");
  endtask

  task automatic testZeroWrite();
    wrBuf[0] = 8'hEE; wrCnt = 1; nackPlan = '0;
    runTxn(2'd1, 7'h50, 32'h1A7, 1, 0, 1'b0, 7'h07);
    expClear(); expPush(0, 0, 0); expPush(2, 8'hA0, 0); expPush(2, 8'hA7, 0); expPush(1, 0, 0);
    cmpTrace("R9 R7");
    chk(gotStatus == 8'd0, "R9", "zero-length write status", gotStatus, 0);
    chk(wrIdx == 0, "R11", "no byte pulled for zero length", wrIdx, 0);
  endtask

  task automatic testBackToBack();
    wrCnt = 0; nackPlan = 64'b10;
    clearModel();
    reqOp = 2'd0; reqChip = 7'h21; reqAlen = '0; reqLen = '0; ovfEn = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(status == 8'd0, "R10", "first status at done", status, 0);
    chk(reqReady == 1'b1, "R10", "ready in done cycle", reqReady, 1);
    reqChip = 7'h22;
    @(negedge clk) reqValid = 1'b0;
    chk(done == 1'b0, "R10", "done is one cycle", done, 0);
    while (!done) @(negedge clk);
    gotStatus = status;
    @(negedge clk);
    expClear(); expPush(0, 0, 0); expPush(2, 8'h42, 0); expPush(1, 0, 0);
    expPush(0, 0, 0); expPush(2, 8'h44, 0); expPush(1, 0, 0);
    cmpTrace("R10");
    chk(gotStatus == 8'd1, "R10", "second status", gotStatus, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin rxPlan[i] = '0; wrBuf[i] = '0; rdGot[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProbe(1'b0);
    testProbe(1'b1);
    testWriteFails();
    testChipNack();
    testAddrNack();
    testReadAddr();
    testReadNoAddr();
    testFold();
    testZeroWrite();
    testBackToBack();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule